// File: doc/BRIEF.md
# Registered Virtual-Channel Allocator

This block assigns output virtual channels to input virtual channels in a router with `NP` ports and `NV` virtual channels per port. Route computation happens before this block. Each input VC that holds a routed head flit presents its computed output port. The block then tries to reserve a free virtual channel on that port for it. It is a separable allocator with two stages. In the first stage, every requesting input VC names one candidate output VC: the lowest-numbered VC on its port whose free flag is set. In the second stage, there is one round-robin arbiter per output VC. Each arbiter chooses among every input VC that named that output VC.

A winner's result is stored in per-input-VC registers: the assigned output VC and a lock flag. The free flag of the assigned output VC is cleared in the same clock edge. Switch-allocation requests are built only from the stored lock flag. There is no bypass from the arbiters, so a head flit that wins in one cycle can request the switch only from the next cycle on. This is the pipeline cut between VC allocation and switch allocation. When the tail flit of an input VC leaves the router, its lock is cleared and its output VC becomes free again.

Top module: `vc_alloc_stage`

## Requirements
- R1: After reset, every output VC is free, no input VC is locked, and no switch-allocation request is raised, even when flits are ready.
- R2: An input VC requests only when its request valid is high, it is not locked, and at least one output VC on its computed port is free. Output VCs are numbered globally as port*NV+vc. A port with no free VC, or a port number of NP or more, produces no grant.
- R3: The first stage picks the lowest-numbered free VC on the requested port.
- R4: Each output VC grants at most one input VC per cycle. Its arbiter is round-robin, starts at input VC 0 after reset, and after each grant moves its priority to the input VC just past the winner.
- R5: At the clock edge after a grant, the winner's lock is set and its output-VC register holds the global number of the won VC. The free flag of that VC is cleared at the same edge.
- R6: The switch-allocation request of an input VC equals its lock flag ANDed with its flit-ready input. In the cycle an input VC wins, its switch-allocation request stays low.
- R7: A tail release on a locked input VC clears the lock and sets the free flag of its output VC at the next edge. A tail release on an unlocked input VC changes nothing.
- R8: A locked input VC receives no further grant, even while its request valid stays high, and its output-VC register is kept.
- R9: No output VC is held by more than one locked input VC. An output VC's free flag is clear whenever one is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NP*NV | Input VC holds a routed head flit wanting an output VC |
| req_port | input | NP*NV*PW | Computed output port per input VC, PW bits each |
| flit_ready | input | NP*NV | Input VC has a flit ready for switch allocation |
| tail_release | input | NP*NV | Tail flit of the input VC leaves the router |
| va_grant | output | NP*NV | Input VC wins an output VC this cycle |
| vc_locked | output | NP*NV | Registered lock flag per input VC |
| out_vc | output | NP*NV*OW | Registered assigned output VC per input VC |
| out_vc_free | output | NP*NV | Free flag per output VC |
| sa_req | output | NP*NV | Switch-allocation request per input VC |

## Verification
A single request on an idle port shows the lowest-VC choice and the one-cycle delay from grant to switch request. A second request on the same port then takes the next VC. A third request on that port is refused because every VC there is taken. Two input VCs asking for the same port in the same cycle show the arbiter pick and show the loser moving to the next free VC one cycle later. Repeating that contention after both VCs are released shows the priority moving past the previous winner. Tail releases on locked and unlocked input VCs separate a real release from one that must be ignored. A request that stays high while its VC is locked checks that no second grant is made.

// File: rtl/vc_alloc_stage.sv
module vc_alloc_stage #(
  parameter int NP = 4,
  parameter int NV = 2,
  localparam int NI = NP * NV,
  localparam int NO = NP * NV,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int OW = (NO > 1) ? $clog2(NO) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NI-1:0]      req_valid,
  input  logic [NI*PW-1:0]   req_port,
  input  logic [NI-1:0]      flit_ready,
  input  logic [NI-1:0]      tail_release,
  output logic [NI-1:0]      va_grant,
  output logic [NI-1:0]      vc_locked,
  output logic [NI*OW-1:0]   out_vc,
  output logic [NO-1:0]      out_vc_free,
  output logic [NI-1:0]      sa_req
);

  logic [NO-1:0] avail_q;
  logic [NI-1:0] lock_q;
  logic [OW-1:0] ovc_q  [NI];
  logic [OW-1:0] ptr_q  [NO];
  logic [OW-1:0] ptr_nx [NO];
  logic [OW-1:0] cand   [NI];
  logic [NI-1:0] cand_ok;
  logic [NI-1:0] active;
  logic [NI-1:0] vreq   [NO];
  logic [NI-1:0] vwin   [NO];
  logic [NI-1:0] holder [NO];

  // first stage: lowest free VC on the routed port
  always_comb begin
    for (int i = 0; i < NI; i++) begin
      int base;
      base = int'(req_port[i*PW +: PW]) * NV;
      cand_ok[i] = 1'b0;
      cand[i] = '0;
      if (int'(req_port[i*PW +: PW]) < NP) begin
        for (int v = NV - 1; v >= 0; v--) begin
          if (avail_q[base + v]) begin
            cand_ok[i] = 1'b1;
            cand[i] = OW'(base + v);
          end
        end
      end
    end
  end

  assign active = req_valid & ~lock_q & cand_ok;

  // second stage: round-robin arbiter per output VC
  always_comb begin
    for (int o = 0; o < NO; o++) begin
      logic found;
      found = 1'b0;
      vwin[o] = '0;
      ptr_nx[o] = ptr_q[o];
      for (int i = 0; i < NI; i++)
        vreq[o][i] = active[i] && (cand[i] == OW'(o));
      for (int k = 0; k < NI; k++) begin
        int idx;
        idx = (int'(ptr_q[o]) + k) % NI;
        if (!found && vreq[o][idx]) begin
          found = 1'b1;
          vwin[o][idx] = 1'b1;
          ptr_nx[o] = OW'((idx + 1) % NI);
        end
      end
    end
  end

  always_comb begin
    va_grant = '0;
    for (int o = 0; o < NO; o++) va_grant = va_grant | vwin[o];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail_q <= '1;
      lock_q  <= '0;
      for (int i = 0; i < NI; i++) ovc_q[i] <= '0;
      for (int o = 0; o < NO; o++) ptr_q[o] <= '0;
    end else begin
      for (int i = 0; i < NI; i++) begin
        if (tail_release[i] && lock_q[i]) begin
          lock_q[i] <= 1'b0;
          avail_q[ovc_q[i]] <= 1'b1;
        end else if (va_grant[i]) begin
          lock_q[i] <= 1'b1;
          ovc_q[i] <= cand[i];
          avail_q[cand[i]] <= 1'b0;
        end
      end
      for (int o = 0; o < NO; o++) ptr_q[o] <= ptr_nx[o];
    end
  end

  assign vc_locked   = lock_q;
  assign out_vc_free = avail_q;
  assign sa_req      = lock_q & flit_ready;

  generate
    for (genvar gi = 0; gi < NI; gi++) begin : g_out
      assign out_vc[gi*OW +: OW] = ovc_q[gi];
    end
  endgenerate

  always_comb begin
    for (int o = 0; o < NO; o++)
      for (int i = 0; i < NI; i++)
        holder[o][i] = lock_q[i] && (ovc_q[i] == OW'(o));
  end

  generate
    for (genvar go = 0; go < NO; go++) begin : g_chk_o
      assert_grant_avail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|vwin[go]) |-> avail_q[go]);
      assert_one_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vwin[go]));
      assert_clear_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|vwin[go]) |=> !avail_q[go]);
      assert_single_holder_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(holder[go]) <= 1);
      assert_held_not_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        avail_q[go] |-> (holder[go] == '0));
    end
    for (genvar gj = 0; gj < NI; gj++) begin : g_chk_i
      assert_no_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        va_grant[gj] |-> !sa_req[gj]);
      assert_release_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_release[gj] && lock_q[gj]) |=> !lock_q[gj]);
      assert_locked_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[gj] |-> !va_grant[gj]);
    end
  endgenerate

endmodule

// File: tb/test_vc_alloc_stage.sv
module test_vc_alloc_stage;
  localparam int NP = 4, NV = 2, NI = 8, PW = 2, OW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NI-1:0] req_valid, flit_ready, tail_release;
  logic [NI*PW-1:0] req_port;
  logic [NI-1:0] va_grant, vc_locked, out_vc_free, sa_req;
  logic [NI*OW-1:0] out_vc;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  vc_alloc_stage #(.NP(NP), .NV(NV)) i_vc_alloc_stage (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .flit_ready(flit_ready), .tail_release(tail_release), .va_grant(va_grant),
    .vc_locked(vc_locked), .out_vc(out_vc), .out_vc_free(out_vc_free), .sa_req(sa_req));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [OW-1:0] ovc(input int i);
    return out_vc[i*OW +: OW];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_valid = '0; req_port = '0; flit_ready = '0; tail_release = '0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    flit_ready = '1;
    #1;
    chk(out_vc_free == 8'hFF, "R1 free flags", out_vc_free, 8'hFF);
    chk(vc_locked == 8'h00, "R1 locks", vc_locked, 0);
    chk(sa_req == 8'h00, "R1 sa_req", sa_req, 0);
    flit_ready = '0;
  endtask

  task automatic t_single_port();
    do_reset();
    req_valid[0] = 1'b1; req_port[0*PW +: PW] = 2'd2; flit_ready[0] = 1'b1;
    #1;
    chk(va_grant == 8'h01, "R3 grant input0", va_grant, 8'h01);
    chk(sa_req[0] == 1'b0, "R6 no bypass", sa_req[0], 0);
    step();
    chk(vc_locked[0] == 1'b1, "R5 lock set", vc_locked[0], 1);
    chk(ovc(0) == 3'd4, "R3 lowest VC on port 2", ovc(0), 4);
    chk(out_vc_free == 8'hEF, "R5 free cleared", out_vc_free, 8'hEF);
    chk(sa_req[0] == 1'b1, "R6 sa_req after lock", sa_req[0], 1);
    chk(va_grant[0] == 1'b0, "R8 no regrant", va_grant[0], 0);
    req_valid[1] = 1'b1; req_port[1*PW +: PW] = 2'd2;
    #1;
    chk(va_grant == 8'h02, "R3 second grant", va_grant, 8'h02);
    step();
    chk(ovc(1) == 3'd5, "R3 next VC", ovc(1), 5);
    chk(ovc(0) == 3'd4, "R8 out_vc kept", ovc(0), 4);
    chk(out_vc_free == 8'hCF, "R5 both taken", out_vc_free, 8'hCF);
    req_valid[0] = 1'b0; req_valid[1] = 1'b0;
    req_valid[2] = 1'b1; req_port[2*PW +: PW] = 2'd2;
    tail_release[3] = 1'b1;
    #1;
    chk(va_grant == 8'h00, "R2 port full", va_grant, 0);
    step();
    chk(out_vc_free == 8'hCF, "R7 release ignored when unlocked", out_vc_free, 8'hCF);
    chk(vc_locked == 8'h03, "R7 locks unchanged", vc_locked, 8'h03);
    tail_release[3] = 1'b0; tail_release[0] = 1'b1;
    #1;
    chk(va_grant == 8'h00, "R2 still full during release", va_grant, 0);
    step();
    tail_release[0] = 1'b0;
    chk(out_vc_free[4] == 1'b1, "R7 VC freed", out_vc_free[4], 1);
    chk(vc_locked[0] == 1'b0, "R7 lock cleared", vc_locked[0], 0);
    chk(sa_req[0] == 1'b0, "R6 sa_req drops with lock", sa_req[0], 0);
    #1;
    chk(va_grant == 8'h04, "R2 waiting input granted", va_grant, 8'h04);
    step();
    chk(ovc(2) == 3'd4 && vc_locked[2], "R5 reused VC", ovc(2), 4);
    req_valid = '0;
    req_valid[6] = 1'b1; req_port[6*PW +: PW] = 2'd3;
    for (int k = 0; k < 1; k++) begin
      #1;
      chk(va_grant == 8'h40, "R2 port 3 grant", va_grant, 8'h40);
    end
    step();
    chk(ovc(6) == 3'd6, "R2 global numbering", ovc(6), 6);
    req_valid = '0;
  endtask

  task automatic t_round_robin();
    do_reset();
    req_valid[3] = 1'b1; req_port[3*PW +: PW] = 2'd1;
    req_valid[5] = 1'b1; req_port[5*PW +: PW] = 2'd1;
    #1;
    chk(va_grant == 8'h08, "R4 first pick from reset priority", va_grant, 8'h08);
    step();
    chk(ovc(3) == 3'd2, "R4 winner VC", ovc(3), 2);
    #1;
    chk(va_grant == 8'h20, "R4 loser retries", va_grant, 8'h20);
    step();
    chk(ovc(5) == 3'd3, "R3 loser gets next VC", ovc(5), 3);
    req_valid = '0;
    tail_release[3] = 1'b1; tail_release[5] = 1'b1;
    step();
    tail_release = '0;
    chk(out_vc_free == 8'hFF && vc_locked == 8'h00, "R7 both released", out_vc_free, 8'hFF);
    req_valid[3] = 1'b1; req_valid[5] = 1'b1;
    #1;
    chk(va_grant == 8'h20, "R4 priority moved past winner", va_grant, 8'h20);
    step();
    chk(ovc(5) == 3'd2, "R4 rotated winner VC", ovc(5), 2);
    req_valid = '0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_single_port();
        t_round_robin();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule